// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A base address is captured from the external bus when an address strobe is seen at a rising clock edge. The block then steps through the remaining addresses of the aligned group of four that holds the base, one step per clock while the advance input is asserted. Only the two low address bits move; the upper bits keep the captured value for the whole burst.

The stepping order is a static choice. Linear order counts the low bits upward and wraps within the group. Interleaved order XORs the captured low bits with a running step count. Deasserting advance freezes the address. A new strobe at any time restarts the burst from a fresh base. There are two strobes: a controller-side strobe that always loads, and a processor-side strobe that loads only while the primary chip enable is asserted.

Top module: `burst_addr_seq`

## Requirements
- R1: With `strobe_ctl_n` low at a rising edge, `addr_out` equals the `addr_in` sampled at that edge and `burst_active` is 1 from the next sample point on, whatever `chip_en_n` is.
- R2: `strobe_cpu_n` low loads the base as in R1 only when `chip_en_n` is low at the same edge; with `chip_en_n` high it has no effect on `addr_out`.
- R3: In linear order, each edge with `advance_n` low during a burst and no strobe adds 1 modulo 4 to `addr_out[1:0]`; `addr_out[ADDR_W-1:2]` never changes during a burst.
- R4: In interleaved order, after n advances (n taken modulo 4) `addr_out[1:0]` equals the captured low bits XOR n; a base ending in 01 gives 01, 00, 11, 10.
- R5: `order_sel` = 0 selects linear order and `order_sel` = 1 selects interleaved order; the output follows the current level of `order_sel`.
- R6: An edge with `advance_n` high and no strobe leaves `addr_out` unchanged, suspending the burst.
- R7: The fourth advance after a load returns `addr_out` to the captured base address in both orders.
- R8: A strobe that loads takes priority over a simultaneous advance; a load during a burst restarts the sequence at the new base.
- R9: A synchronous reset (`rst` high at an edge) sets `addr_out` to 0 and `burst_active` to 0; advances before the first load leave `addr_out` at 0.
- R10: All strobe, advance, enable and address inputs act at the rising edge only; outputs change one register stage after the edge at which an input is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External base address |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low, gated by chip enable |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low, ungated |
| advance_n | input | 1 | Burst advance, active low |
| chip_en_n | input | 1 | Primary chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current word address |
| burst_active | output | 1 | High once a base has been loaded since reset |

## Verification
A wrong step count shows at the next sample point as a wrong value on the two low address bits, and it stays wrong until the next strobe, because the count is the only state that moves during a burst. A base register that captures at the wrong time shows as an upper-bit change in the middle of a burst, or as a missing reload one cycle after a strobe. A wrong gating of the processor strobe shows as a reload that should not happen, which the address reveals one cycle later unless the new bus value equals the old base, so random stimulus keeps the bus value changing.

// File: rtl/bas_pkg.sv
`timescale 1ns/1ps
package bas_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low address bits after 'step' advances from 'base_lo' under order 'ord'.
  function automatic logic [1:0] seq_low2(input logic [1:0] base_lo,
                                          input logic [1:0] step,
                                          input order_e     ord);
    logic [1:0] r;
    if (ord == ORD_LINEAR) r = base_lo + step;
    else                   r = base_lo ^ step;
    return r;
  endfunction

endpackage

// File: rtl/bas_event_dec.sv
`timescale 1ns/1ps
// Decides, per edge, whether the sequencer loads, steps or holds.
module bas_event_dec (
  input  logic strobe_cpu_n,
  input  logic strobe_ctl_n,
  input  logic advance_n,
  input  logic chip_en_n,
  input  logic active,
  output logic load_evt,
  output logic step_evt
);
  logic cpu_load;
  logic ctl_load;

  always_comb begin
    cpu_load = !strobe_cpu_n && !chip_en_n;
    ctl_load = !strobe_ctl_n;
    load_evt = cpu_load || ctl_load;
    step_evt = active && !advance_n && !load_evt;
  end
endmodule

// File: rtl/bas_step_ctr.sv
`timescale 1ns/1ps
// Step counter inside the aligned group; wraps naturally at 2**CW.
module bas_step_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_evt,
  input  logic          step_evt,
  output logic [CW-1:0] step_cnt
);
  always_ff @(posedge clk) begin
    if (rst)           step_cnt <= '0;
    else if (load_evt) step_cnt <= '0;
    else if (step_evt) step_cnt <= step_cnt + 1'b1;
  end
endmodule

// File: rtl/bas_base_reg.sv
`timescale 1ns/1ps
// Holds the captured base address and the burst-active flag.
module bas_base_reg #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_evt,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      active <= 1'b0;
    end else if (load_evt) begin
      q      <= d;
      active <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq #(
  parameter int ADDR_W   = 15,
  parameter int SEQ_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              advance_n,
  input  logic              chip_en_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);
  import bas_pkg::*;

  localparam int UPPER_W = ADDR_W - SEQ_BITS;

  logic                load_evt;
  logic                step_evt;
  logic [SEQ_BITS-1:0] step_cnt;
  logic [ADDR_W-1:0]   base_q;
  logic [SEQ_BITS-1:0] low_bits;
  order_e              ord;

  assign ord = order_e'(order_sel);

  bas_event_dec u_dec (
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .chip_en_n    (chip_en_n),
    .active       (burst_active),
    .load_evt     (load_evt),
    .step_evt     (step_evt)
  );

  bas_step_ctr #(.CW(SEQ_BITS)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .step_cnt (step_cnt)
  );

  bas_base_reg #(.W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .d        (addr_in),
    .q        (base_q),
    .active   (burst_active)
  );

  generate
    if (SEQ_BITS == 2) begin : g_map2
      assign low_bits = seq_low2(base_q[1:0], step_cnt, ord);
    end else begin : g_mapn
      assign low_bits = (ord == ORD_LINEAR) ? base_q[SEQ_BITS-1:0] + step_cnt
                                            : base_q[SEQ_BITS-1:0] ^ step_cnt;
    end
    if (UPPER_W > 0) begin : g_upper
      assign addr_out = {base_q[ADDR_W-1:SEQ_BITS], low_bits};
    end else begin : g_noupper
      assign addr_out = low_bits;
    end
  endgenerate
endmodule

// File: rtl/bas_checker.sv
`timescale 1ns/1ps
module bas_checker #(
  parameter int ADDR_W   = 15,
  parameter int SEQ_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              advance_n,
  input logic              chip_en_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active,
  input logic              load_evt,
  input logic              step_evt
);
  // R1
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_ctl_n |=> (addr_out == $past(addr_in)) && burst_active);

  // R2
  cpu_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && chip_en_n && strobe_ctl_n && advance_n)
      |=> !$stable(order_sel) || $stable(addr_out));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_evt && order_sel == 1'b0)
      |=> (order_sel != 1'b0) ||
          (addr_out[SEQ_BITS-1:0] == $past(addr_out[SEQ_BITS-1:0]) + 1'b1));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(addr_out[ADDR_W-1:SEQ_BITS]));

  // R6
  suspend_chk: assert property (@(posedge clk) disable iff (rst)
    (advance_n && !load_evt) |=> !$stable(order_sel) || $stable(addr_out));

  // R8
  priority_chk: assert property (@(posedge clk) disable iff (rst)
    (load_evt && !advance_n) |=> addr_out == $past(addr_in));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !burst_active && addr_out == '0);
endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .SEQ_BITS(SEQ_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_in      (addr_in),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .advance_n    (advance_n),
  .chip_en_n    (chip_en_n),
  .order_sel    (order_sel),
  .addr_out     (addr_out),
  .burst_active (burst_active),
  .load_evt     (load_evt),
  .step_evt     (step_evt)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          strobe_cpu_n = 1'b1;
  logic          strobe_ctl_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          chip_en_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [AW-1:0] m_base = '0;
  int            m_k = 0;
  bit            m_act = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .chip_en_n(chip_en_n), .order_sel(order_sel),
    .addr_out(addr_out), .burst_active(burst_active)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b, input int k,
                                             input logic ord);
    int lo;
    if (ord) lo = int'(b[1:0]) ^ k;
    else     lo = (int'(b[1:0]) + k) % 4;
    return {b[AW-1:2], 2'(lo)};
  endfunction

  task automatic report(input string req);
    logic [AW-1:0] e;
    e = exp_addr(m_base, m_k, order_sel);
    checks++;
    if (addr_out !== e || burst_active !== m_act) begin
      errors++;
      $display("FAIL %s: addr=%h act=%0b expected addr=%h act=%0b",
               req, addr_out, burst_active, e, m_act);
    end
  endtask

  // drive at negedge, clock in, update model, check at next negedge
  task automatic cyc(input logic r, input logic [AW-1:0] a, input logic cpu_n,
                     input logic ctl_n, input logic adv_n, input logic ce_n,
                     input string req);
    rst = r; addr_in = a; strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n;
    advance_n = adv_n; chip_en_n = ce_n;
    @(posedge clk);
    if (r) begin
      m_base = '0; m_k = 0; m_act = 0;
    end else if (!ctl_n || (!cpu_n && !ce_n)) begin
      m_base = a; m_k = 0; m_act = 1;
    end else if (m_act && !adv_n) begin
      m_k = (m_k + 1) % 4;
    end
    @(negedge clk);
    report(req);
  endtask

  task automatic walk(input logic [1:0] exp_seq [4], input string req);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (addr_out[1:0] !== exp_seq[i]) begin
        errors++;
        $display("FAIL %s: low=%b expected low=%b", req, addr_out[1:0], exp_seq[i]);
      end
      cyc(0, 15'h7FFF, 1, 1, 0, 1, req);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0] seq [4];
    @(negedge clk);
    cyc(1, 15'h1234, 0, 0, 0, 0, "R9");
    cyc(0, 15'h0000, 1, 1, 0, 1, "R9");   // advance before any load ignored
    cyc(0, 15'h0000, 1, 1, 0, 1, "R9");

    // R5 R3: linear from ..01 gives 01 10 11 00, then wrap R7
    order_sel = 1'b0;
    cyc(0, 15'h2A45, 1, 0, 1, 1, "R1");
    seq = '{2'b01, 2'b10, 2'b11, 2'b00};
    walk(seq, "R3");
    report("R7");

    // R4: interleaved from ..01 gives 01 00 11 10
    order_sel = 1'b1;
    cyc(0, 15'h1001, 1, 0, 1, 1, "R1");
    seq = '{2'b01, 2'b00, 2'b11, 2'b10};
    walk(seq, "R4");
    report("R7");

    // R6 suspend
    cyc(0, 15'h0AB6, 1, 0, 1, 1, "R1");
    cyc(0, 15'h0000, 1, 1, 0, 1, "R6");
    cyc(0, 15'h0000, 1, 1, 1, 1, "R6");
    cyc(0, 15'h0000, 1, 1, 1, 1, "R6");
    cyc(0, 15'h0000, 1, 1, 0, 1, "R6");

    // R2 gated processor strobe
    cyc(0, 15'h5555, 0, 1, 1, 1, "R2");
    cyc(0, 15'h3333, 0, 1, 1, 0, "R2");
    // R1 controller strobe with chip disabled
    cyc(0, 15'h4443, 1, 0, 1, 1, "R1");

    // R8 priority and mid-burst restart
    cyc(0, 15'h0000, 1, 1, 0, 1, "R8");
    cyc(0, 15'h6662, 0, 0, 0, 0, "R8");
    cyc(0, 15'h0000, 1, 1, 0, 1, "R8");

    // R10: input pulse held only between edges leaves output alone
    strobe_ctl_n = 1'b0; addr_in = 15'h7777; #1; strobe_ctl_n = 1'b1; #1;
    report("R10");

    // random phase (R1..R8 together)
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic cpu_n, ctl_n, adv_n, ce_n;
      a = AW'($urandom);
      cpu_n = ($urandom % 5) != 0;
      ctl_n = ($urandom % 6) != 0;
      adv_n = ($urandom % 3) == 0;
      ce_n  = $urandom % 2;
      if (($urandom % 50) == 0) order_sel = ~order_sel;
      cyc(($urandom % 400) == 0, a, cpu_n, ctl_n, adv_n, ce_n, "R3/R4 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule